// File: doc/BRIEF.md
# Write-One-to-Clear Interrupt Status Unit

This block collects single-cycle event pulses from the transmit DMA path, the receive DMA path and the link interface of a small Ethernet MAC. Each pulse sets its own sticky bit in a status register. Software reads that register to find out what happened and clears bits by writing ones to them. A separate enable register selects which pending bits drive the single level-sensitive interrupt line.

Access is through a plain 32-bit register port. Writes take effect at a clock edge, and read data follows the address combinationally. The port carries no stream data, so it has no valid/ready handshake: every write strobe is accepted at the next edge. The status word sits at byte offset 0x08 and the enable word at offset 0x0C. Any other offset reads as zero and ignores writes.

Top module: `w1c_irq_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, the status register, the enable register and `irq` are all zero.
- R2: A pulse on `tx_evt[i]` sets status bit i (i = 0..5), a pulse on `rx_evt[i]` sets status bit 8+i (i = 0..5), and a pulse on `link_evt` sets status bit 16. Each bit is set at the clock edge where its pulse is sampled.
- R3: A status bit stays set until software clears it. It is latched whether or not its enable bit is set.
- R4: A write to offset 0x08 clears every status bit written as one and leaves every bit written as zero unchanged.
- R5: Writing 0x1FFFFFF to offset 0x08 clears all pending status bits in one write.
- R6: If a new event and a clearing write reach the same status bit at the same edge, the bit stays set.
- R7: The enable register at offset 0x0C reads back the value last written to it, restricted to the implemented bit positions.
- R8: `irq` is registered. It goes high one cycle after (status AND enable) becomes non-zero, and it goes low one cycle after that value returns to zero.
- R9: Unimplemented bit positions (any bit outside the mask 0x13F3F) read as zero in both registers and ignore writes. Offsets other than 0x08 and 0x0C read as zero, and writes to them change nothing.
- R10: Reading the status register and writing the same value back clears exactly the bits that were read as set. Events that arrive between the read and the write stay pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 8 | Byte offset of the register being accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tx_evt | input | 6 | Transmit event pulses: done, DMA stopped, buffer unavailable, timeout, underflow, early |
| rx_evt | input | 6 | Receive event pulses: done, buffer unavailable, DMA stopped, timeout, overflow, early |
| link_evt | input | 1 | Link status change pulse |
| irq | output | 1 | Level interrupt, registered |

## Verification
The most delicate case is an event arriving in the same cycle as a clear of the same bit. A design that lets the clear take priority would silently lose that event. The bench also takes a snapshot with a read, injects an event, and then writes the snapshot back. A design that cleared all bits, or cleared the bits present at write time, would lose the injected event. The bench counts the exact cycle in which `irq` rises and falls, which catches an unregistered or doubly registered output. It also confirms that masked sources still latch and that writes to unused bits or unused offsets leave no trace.

// File: rtl/w1c_irq_pkg.sv
package w1c_irq_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_EN   = 2'd2
  } reg_sel_e;

  // Build the implemented-bit mask from the source layout.
  function automatic logic [31:0] impl_mask(int tx_n, int tx_base,
                                            int rx_n, int rx_base,
                                            int link_pos);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < tx_n; i++) m[tx_base + i] = 1'b1;
    for (int i = 0; i < rx_n; i++) m[rx_base + i] = 1'b1;
    m[link_pos] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/w1c_src_map.sv
module w1c_src_map #(
  parameter int DATA_W   = 32,
  parameter int TX_N     = 6,
  parameter int TX_BASE  = 0,
  parameter int RX_N     = 6,
  parameter int RX_BASE  = 8,
  parameter int LINK_POS = 16
) (
  input  logic [TX_N-1:0]   tx_evt,
  input  logic [RX_N-1:0]   rx_evt,
  input  logic              link_evt,
  output logic [DATA_W-1:0] set_vec
);
  // Place each source pulse at its fixed position in the status word.
  always_comb begin
    set_vec = '0;
    for (int i = 0; i < TX_N; i++) set_vec[TX_BASE + i] = tx_evt[i];
    for (int i = 0; i < RX_N; i++) set_vec[RX_BASE + i] = rx_evt[i];
    set_vec[LINK_POS] = link_evt;
  end
endmodule

// File: rtl/w1c_sticky_bank.sv
module w1c_sticky_bank #(
  parameter int          DATA_W = 32,
  parameter logic [31:0] IMPL   = 32'h0001_3F3F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_vec,
  input  logic [DATA_W-1:0] clr_vec,
  output logic [DATA_W-1:0] stat_q
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (IMPL[b]) begin : g_flop
      // A set at the same edge as a clear wins, so no event is lost.
      always_ff @(posedge clk) begin
        if (!rst_n) stat_q[b] <= 1'b0;
        else        stat_q[b] <= set_vec[b] | (stat_q[b] & ~clr_vec[b]);
      end
    end else begin : g_tie
      assign stat_q[b] = 1'b0;
    end
  end
endmodule

// File: rtl/w1c_irq_gen.sv
module w1c_irq_gen #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] stat_q,
  input  logic [DATA_W-1:0] en_q,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(stat_q & en_q);
  end
endmodule

// File: rtl/w1c_irq_unit.sv
module w1c_irq_unit
  import w1c_irq_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          ADDR_W   = 8,
  parameter int          TX_N     = 6,
  parameter int          TX_BASE  = 0,
  parameter int          RX_N     = 6,
  parameter int          RX_BASE  = 8,
  parameter int          LINK_POS = 16,
  parameter logic [7:0]  STAT_OFS = 8'h08,
  parameter logic [7:0]  EN_OFS   = 8'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [TX_N-1:0]   tx_evt,
  input  logic [RX_N-1:0]   rx_evt,
  input  logic              link_evt,
  output logic              irq
);
  localparam logic [31:0] IMPL = impl_mask(TX_N, TX_BASE, RX_N, RX_BASE, LINK_POS);
  localparam logic [DATA_W-1:0] IMPL_W = DATA_W'(IMPL);

  reg_sel_e          sel;
  logic [DATA_W-1:0] set_vec;
  logic [DATA_W-1:0] clr_vec;
  logic [DATA_W-1:0] stat_q;
  logic [DATA_W-1:0] en_q;

  always_comb begin
    if (bus_addr == ADDR_W'(STAT_OFS))    sel = SEL_STAT;
    else if (bus_addr == ADDR_W'(EN_OFS)) sel = SEL_EN;
    else                                  sel = SEL_NONE;
  end

  w1c_src_map #(
    .DATA_W(DATA_W), .TX_N(TX_N), .TX_BASE(TX_BASE),
    .RX_N(RX_N), .RX_BASE(RX_BASE), .LINK_POS(LINK_POS)
  ) map_i (
    .tx_evt(tx_evt), .rx_evt(rx_evt), .link_evt(link_evt), .set_vec(set_vec)
  );

  assign clr_vec = (bus_wr_en && sel == SEL_STAT) ? bus_wdata : '0;

  w1c_sticky_bank #(.DATA_W(DATA_W), .IMPL(IMPL)) bank_i (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .stat_q(stat_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                          en_q <= '0;
    else if (bus_wr_en && sel == SEL_EN) en_q <= bus_wdata & IMPL_W;
  end

  always_comb begin
    case (sel)
      SEL_STAT: bus_rdata = stat_q;
      SEL_EN:   bus_rdata = en_q;
      default:  bus_rdata = '0;
    endcase
  end

  w1c_irq_gen #(.DATA_W(DATA_W)) irq_i (
    .clk(clk), .rst_n(rst_n), .stat_q(stat_q), .en_q(en_q), .irq(irq)
  );
endmodule

// File: rtl/w1c_irq_unit_chk.sv
module w1c_irq_unit_chk #(
  parameter int          DATA_W = 32,
  parameter int          ADDR_W = 8,
  parameter logic [31:0] IMPL   = 32'h0001_3F3F,
  parameter logic [7:0]  STAT_OFS = 8'h08
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] set_vec,
  input logic [DATA_W-1:0] stat_q,
  input logic [DATA_W-1:0] en_q,
  input logic              irq
);
  localparam logic [DATA_W-1:0] IMPL_W = DATA_W'(IMPL);
  logic stat_wr;
  assign stat_wr = bus_wr_en && (bus_addr == ADDR_W'(STAT_OFS));

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (stat_q == '0 && en_q == '0 && !irq));

  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((stat_q & $past(set_vec & IMPL_W)) == $past(set_vec & IMPL_W)));

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  assert_clear_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && set_vec == '0) |=> ((stat_q & $past(bus_wdata)) == '0));

  assert_set_beats_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && ((set_vec & bus_wdata & IMPL_W) != '0))
      |=> ((stat_q & $past(set_vec & bus_wdata & IMPL_W)) != '0));

  assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_q & en_q)) |=> irq);

  assert_irq_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(stat_q & en_q)) |=> !irq);

  assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~IMPL_W) == '0) && ((en_q & ~IMPL_W) == '0));
endmodule

bind w1c_irq_unit w1c_irq_unit_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IMPL(IMPL), .STAT_OFS(STAT_OFS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .set_vec(set_vec), .stat_q(stat_q), .en_q(en_q), .irq(irq)
);

// File: tb/w1c_irq_unit_tb.sv
module w1c_irq_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  tx_evt = '0;
  logic [5:0]  rx_evt = '0;
  logic        link_evt = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_STAT = 8'h08;
  localparam logic [7:0] A_EN   = 8'h0C;

  always #2.5 clk = ~clk;

  w1c_irq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_evt(tx_evt),
    .rx_evt(rx_evt), .link_evt(link_evt), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #0.5 d = bus_rdata;
  endtask

  task automatic pulse(logic [5:0] t, logic [5:0] r, logic l);
    @(negedge clk);
    tx_evt = t; rx_evt = r; link_evt = l;
    @(negedge clk);
    tx_evt = '0; rx_evt = '0; link_evt = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_STAT, v); chk("R1 status", v, 0);
    rd(A_EN, v);   chk("R1 enable", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_sources;
    logic [31:0] v;
    for (int i = 0; i < 6; i++) begin
      pulse(6'(1 << i), 6'b0, 1'b0);
      rd(A_STAT, v); chk("R2 tx source", v, 32'(1) << i);
      wr(A_STAT, v);
      pulse(6'b0, 6'(1 << i), 1'b0);
      rd(A_STAT, v); chk("R2 rx source", v, 32'(1) << (8 + i));
      wr(A_STAT, v);
    end
    pulse(6'b0, 6'b0, 1'b1);
    rd(A_STAT, v); chk("R2 link source", v, 32'h0001_0000);
    wr(A_STAT, v);
  endtask

  task automatic t_sticky_masked;
    logic [31:0] v;
    wr(A_EN, 32'h0);
    pulse(6'b0, 6'b000010, 1'b0);
    repeat (5) @(negedge clk);
    rd(A_STAT, v); chk("R3 held while masked", v, 32'h0000_0200);
    chk("R3 irq masked", {31'b0, irq}, 0);
    wr(A_STAT, 32'h0000_0200);
  endtask

  task automatic t_partial_clear;
    logic [31:0] v;
    pulse(6'b000101, 6'b000001, 1'b0);
    wr(A_STAT, 32'h0000_0005);
    rd(A_STAT, v); chk("R4 partial clear", v, 32'h0000_0100);
    wr(A_STAT, 32'h0000_0100);
  endtask

  task automatic t_clear_all;
    logic [31:0] v;
    pulse(6'h3F, 6'h3F, 1'b1);
    rd(A_STAT, v); chk("R5 all set", v, 32'h0001_3F3F);
    wr(A_STAT, 32'h01FF_FFFF);
    rd(A_STAT, v); chk("R5 all cleared", v, 0);
  endtask

  task automatic t_same_cycle;
    logic [31:0] v;
    pulse(6'b001000, 6'b000100, 1'b0);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h0000_0408;
    tx_evt = 6'b001000;
    @(negedge clk);
    bus_wr_en = 1'b0; tx_evt = '0;
    rd(A_STAT, v); chk("R6 set wins over clear", v, 32'h0000_0008);
    wr(A_STAT, 32'h0000_0008);
  endtask

  task automatic t_enable_rw;
    logic [31:0] v;
    wr(A_EN, 32'h0000_0101);
    rd(A_EN, v); chk("R7 enable readback", v, 32'h0000_0101);
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, v); chk("R9 enable unused bits", v, 32'h0001_3F3F);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, v); chk("R9 other offset reads zero", v, 0);
    rd(A_EN, v);  chk("R9 other offset write ignored", v, 32'h0001_3F3F);
    rd(A_STAT, v); chk("R9 status untouched", v, 0);
    wr(A_EN, 32'h0);
  endtask

  task automatic t_irq_timing;
    logic [31:0] v;
    wr(A_EN, 32'h0000_0101);
    pulse(6'b010000, 6'b0, 1'b0);
    @(negedge clk); chk("R8 masked source no irq", {31'b0, irq}, 0);
    wr(A_STAT, 32'h0000_0010);
    @(negedge clk);
    rx_evt = 6'b000001;
    @(negedge clk);
    rx_evt = '0;
    chk("R8 irq not yet", {31'b0, irq}, 0);
    @(negedge clk); chk("R8 irq rises", {31'b0, irq}, 1);
    bus_wr_en = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h0000_0100;
    @(negedge clk);
    bus_wr_en = 1'b0;
    chk("R8 irq still high", {31'b0, irq}, 1);
    @(negedge clk); chk("R8 irq falls", {31'b0, irq}, 0);
    rd(A_STAT, v); chk("R8 status clear", v, 0);
    wr(A_EN, 32'h0);
  endtask

  task automatic t_readback;
    logic [31:0] v, w;
    pulse(6'b000001, 6'b000001, 1'b1);
    rd(A_STAT, v); chk("R10 snapshot", v, 32'h0001_0101);
    pulse(6'b000010, 6'b0, 1'b0);
    wr(A_STAT, v);
    rd(A_STAT, w); chk("R10 only snapshot cleared", w, 32'h0000_0002);
    wr(A_STAT, w);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_sources;
    t_sticky_masked;
    t_partial_clear;
    t_clear_all;
    t_same_cycle;
    t_enable_rw;
    t_irq_timing;
    t_readback;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
      end
    join_any
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule